// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Supervisor

This block is the synchronous fault controller of a three-phase gate driver. It watches three single-bit inputs: the output of an overcurrent comparator, a supply-good indication for the low-side supply, and a driver enable. From them it produces a global shutdown request that forces all six gate output channels off. It also produces an active-low fault flag, meant to drive an open-drain pin.

An overcurrent trip must persist through a deglitch window before it counts as real. Once it counts, the fault is latched. The latch is released only after the trip has gone away and a clear-delay counter has then run its full length. That counter takes the place of an external RC timing network: it is held at zero while the trip is present and restarts from zero if a new qualified trip arrives during the count.

A low supply forces shutdown and raises the fault flag, but it is not latched and releases as soon as the supply is good again. A deasserted enable, which has its own deglitch window, forces shutdown without raising the fault flag. After reset the supply is treated as bad until the supply-good input has been sampled high.

Top module: `fault_supervisor`

## Requirements
- R1: A trip input high for fewer than TRIP_FILT_CYC consecutive clock samples never asserts shutdown_o or the fault flag.
- R2: A trip input held high for TRIP_FILT_CYC samples drives shutdown_o to 1 and fault_n_o to 0 on the TRIP_FILT_CYC+2-th rising edge after the trip is first presented.
- R3: While the trip input stays high, the overcurrent fault stays latched, however long that lasts.
- R4: After the trip input falls, shutdown_o and fault_n_o are released on rising edge TRIP_FILT_CYC+CLEAR_CYC+1, and not earlier (supply good, enable high).
- R5: A new qualified trip during the clear count restarts the count, so release is timed from the end of the last trip.
- R6: supply_ok_i low drives shutdown_o=1 and fault_n_o=0 two edges later; it releases two edges after supply_ok_i returns high, with no clear delay.
- R7: enable_i low for EN_FILT_CYC samples drives shutdown_o to 1 on edge EN_FILT_CYC+1, while fault_n_o stays 1.
- R8: An enable_i low pulse shorter than EN_FILT_CYC samples has no effect on shutdown_o.
- R9: During and after reset, shutdown_o=1 and fault_n_o=0 until supply_ok_i has been sampled high.
- R10: shutdown_o is the OR of the latched overcurrent fault, the supply fault and not-enabled; fault_n_o is low exactly when either of the first two is present, whatever the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_trip_i | input | 1 | Overcurrent comparator output, 1 = trip |
| supply_ok_i | input | 1 | Low-side supply good, 1 = good |
| enable_i | input | 1 | Driver enable, 1 = enabled |
| shutdown_o | output | 1 | Forces all six gate channels off when 1 |
| fault_n_o | output | 1 | Fault flag, 0 = overcurrent or supply fault |

## Verification
Every result has a fixed latency from the edge that first samples the stimulus. Counted in rising edges, the delays are: trip to fault, TRIP_FILT_CYC+2; supply change to outputs, 2; enable fall to shutdown, EN_FILT_CYC+1; trip removal to release, TRIP_FILT_CYC+CLEAR_CYC+1. The bench drives inputs on falling edges and advances a counted number of falling edges before it samples. It checks each boundary on both sides: one edge before the result is due, where the old value must still hold, and on the edge where the new value must appear. Glitch tests sample the outputs on every cycle of a window of stimulus and aftermath.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // fault sources feeding the output stage
  typedef struct packed {
    logic oc;   // latched overcurrent
    logic uv;   // low-side supply not good
    logic dis;  // driver disabled
  } fsup_cause_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fsup_deglitch.sv
module fsup_deglitch #(
  parameter int unsigned WIN     = 4,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = fsup_pkg::cnt_width(WIN);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  // the output follows the input only after WIN consecutive disagreeing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else if (raw_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> ($past(raw_i) == filt_q)); // R1
  AST_FILT_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q <= LAST)); // R8
endmodule

// File: rtl/fsup_oc_latch.sv
module fsup_oc_latch #(
  parameter int unsigned CLEAR_CYC = 190000
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,   // deglitched trip
  output logic oc_o      // latched overcurrent fault
);
  localparam int unsigned CW = fsup_pkg::cnt_width(CLEAR_CYC);
  localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

  logic [CW-1:0] tmr_q;
  logic          oc_q;
  logic          expire;

  assign expire = oc_q && !trip_i && (tmr_q == LAST);

  // timer held at zero while the trip is present, counts only while latched
  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q  <= 1'b0;
      tmr_q <= '0;
    end else if (trip_i) begin
      oc_q  <= 1'b1;
      tmr_q <= '0;
    end else if (expire) begin
      oc_q  <= 1'b0;
      tmr_q <= '0;
    end else if (oc_q) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign oc_o = oc_q;

  AST_TRIP_SETS_LATCH: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> oc_q); // R2
  AST_HOLD_WHILE_TRIP: assert property (@(posedge clk) disable iff (rst)
    $fell(oc_q) |-> !$past(trip_i)); // R3
  AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    tmr_q <= LAST); // R4
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> (tmr_q == '0)); // R5
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int unsigned TRIP_FILT_CYC = 23,
  parameter int unsigned EN_FILT_CYC   = 60,
  parameter int unsigned SUP_FILT_CYC  = 1,
  parameter int unsigned CLEAR_CYC     = 190000
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_trip_i,
  input  logic supply_ok_i,
  input  logic enable_i,
  output logic shutdown_o,
  output logic fault_n_o
);
  import fsup_pkg::*;

  logic        trip_f, sup_f, en_f, oc_lat;
  fsup_cause_t cause;
  logic        shdn_q, flt_n_q;

  fsup_deglitch #(.WIN(TRIP_FILT_CYC), .RST_VAL(1'b0)) i_trip_filt (
    .clk(clk), .rst(rst), .raw_i(oc_trip_i), .filt_o(trip_f));

  // supply considered bad out of reset
  fsup_deglitch #(.WIN(SUP_FILT_CYC), .RST_VAL(1'b0)) i_sup_filt (
    .clk(clk), .rst(rst), .raw_i(supply_ok_i), .filt_o(sup_f));

  fsup_deglitch #(.WIN(EN_FILT_CYC), .RST_VAL(1'b0)) i_en_filt (
    .clk(clk), .rst(rst), .raw_i(enable_i), .filt_o(en_f));

  fsup_oc_latch #(.CLEAR_CYC(CLEAR_CYC)) i_oc_latch (
    .clk(clk), .rst(rst), .trip_i(trip_f), .oc_o(oc_lat));

  always_comb begin
    cause.oc  = oc_lat;
    cause.uv  = !sup_f;
    cause.dis = !en_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shdn_q  <= 1'b1;
      flt_n_q <= 1'b0;
    end else begin
      shdn_q  <= |cause;
      flt_n_q <= !(cause.oc || cause.uv);
    end
  end

  assign shutdown_o = shdn_q;
  assign fault_n_o  = flt_n_q;

  AST_FLAG_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    !fault_n_o |-> shutdown_o); // R10
  AST_UV_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    !sup_f |=> (!fault_n_o && shutdown_o)); // R6
  AST_DIS_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sup_f && !oc_lat && !en_f) |=> (fault_n_o && shutdown_o)); // R7
  AST_OC_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    oc_lat |=> !fault_n_o); // R2
  AST_NOSUP_AFTER_RST: assert property (@(posedge clk)
    $fell(rst) |-> (shutdown_o && !fault_n_o)); // R9
endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int TRIP = 4;
  localparam int ENW  = 6;
  localparam int CLR  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip = 1'b0;
  logic sup = 1'b0;
  logic en = 1'b1;
  logic shdn, flt_n;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor #(.TRIP_FILT_CYC(TRIP), .EN_FILT_CYC(ENW),
                     .SUP_FILT_CYC(1), .CLEAR_CYC(CLR)) i_fault_supervisor (
    .clk(clk), .rst(rst), .oc_trip_i(trip), .supply_ok_i(sup),
    .enable_i(en), .shutdown_o(shdn), .fault_n_o(flt_n));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic exp_sd, input logic exp_fn);
    n_chk++;
    if (shdn !== exp_sd || flt_n !== exp_fn) begin
      n_err++;
      $display("FAIL %s: shutdown=%b fault_n=%b expected shutdown=%b fault_n=%b",
               req, shdn, flt_n, exp_sd, exp_fn);
    end
  endtask

  // R9: reset state and supply qualification
  task automatic t_reset();
    rst = 1'b1; sup = 1'b0; en = 1'b1; trip = 1'b0;
    tick(3);
    expect_out("R9 in reset", 1'b1, 1'b0);
    rst = 1'b0;
    tick(ENW + 10);
    expect_out("R9 supply not yet sampled", 1'b1, 1'b0);
    sup = 1'b1;
    tick(1);
    expect_out("R9 one edge after supply good", 1'b1, 1'b0);
    tick(1);
    expect_out("R9 released", 1'b0, 1'b1);
  endtask

  // R1: short trip pulse ignored
  task automatic t_trip_glitch();
    bit bad = 1'b0;
    trip = 1'b1;
    for (int i = 0; i < TRIP - 1; i++) begin
      tick(1);
      if (shdn !== 1'b0 || flt_n !== 1'b1) bad = 1'b1;
    end
    trip = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (shdn !== 1'b0 || flt_n !== 1'b1) bad = 1'b1;
    end
    n_chk++;
    if (bad) begin
      n_err++;
      $display("FAIL R1 glitch: shutdown=%b fault_n=%b expected shutdown=0 fault_n=1", shdn, flt_n);
    end
  endtask

  // R2 R3 R4: qualified trip, hold, timed release
  task automatic t_trip_latch();
    trip = 1'b1;
    tick(TRIP + 1);
    expect_out("R2 one edge before fault", 1'b0, 1'b1);
    tick(1);
    expect_out("R2 fault asserted", 1'b1, 1'b0);
    tick(3 * CLR);
    expect_out("R3 held during long trip", 1'b1, 1'b0);
    trip = 1'b0;
    tick(TRIP + CLR);
    expect_out("R4 one edge before release", 1'b1, 1'b0);
    tick(1);
    expect_out("R4 released", 1'b0, 1'b1);
  endtask

  // R5: new trip during clear count restarts it
  task automatic t_restart();
    trip = 1'b1;
    tick(TRIP + 2);
    expect_out("R5 first trip latched", 1'b1, 1'b0);
    trip = 1'b0;
    tick(TRIP + CLR / 2);
    trip = 1'b1;
    tick(TRIP);
    trip = 1'b0;
    tick(TRIP + CLR);
    expect_out("R5 still latched after restart", 1'b1, 1'b0);
    tick(1);
    expect_out("R5 released from last trip end", 1'b0, 1'b1);
  endtask

  // R6: supply fault is transparent
  task automatic t_supply();
    sup = 1'b0;
    tick(1);
    expect_out("R6 one edge after supply low", 1'b0, 1'b1);
    tick(1);
    expect_out("R6 supply fault", 1'b1, 1'b0);
    tick(20);
    sup = 1'b1;
    tick(1);
    expect_out("R6 one edge after supply good", 1'b1, 1'b0);
    tick(1);
    expect_out("R6 released without delay", 1'b0, 1'b1);
  endtask

  // R7 R8: enable behaviour
  task automatic t_enable();
    bit bad = 1'b0;
    en = 1'b0;
    tick(ENW);
    expect_out("R7 one edge before disable", 1'b0, 1'b1);
    tick(1);
    expect_out("R7 disabled, no flag", 1'b1, 1'b1);
    en = 1'b1;
    tick(ENW + 1);
    expect_out("R7 re-enabled", 1'b0, 1'b1);
    en = 1'b0;
    for (int i = 0; i < ENW - 1; i++) begin
      tick(1);
      if (shdn !== 1'b0) bad = 1'b1;
    end
    en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (shdn !== 1'b0) bad = 1'b1;
    end
    n_chk++;
    if (bad) begin
      n_err++;
      $display("FAIL R8 enable glitch: shutdown=%b expected shutdown=0", shdn);
    end
  endtask

  // R10: overcurrent flag raised even while disabled
  task automatic t_combined();
    en = 1'b0;
    tick(ENW + 1);
    expect_out("R10 disabled only", 1'b1, 1'b1);
    trip = 1'b1;
    tick(TRIP + 2);
    expect_out("R10 trip while disabled", 1'b1, 1'b0);
    trip = 1'b0;
    tick(TRIP + CLR + 1);
    expect_out("R10 trip cleared, still disabled", 1'b1, 1'b1);
    en = 1'b1;
    tick(ENW + 1);
    expect_out("R10 all clear", 1'b0, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_trip_glitch();
    t_trip_latch();
    t_restart();
    t_supply();
    t_enable();
    t_combined();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule